// File: doc/BRIEF.md
# DMA Trigger and List-Address Unit

This unit is the register front end and descriptor-list address sequencer of a DMA controller. The CPU writes bytes into a 16-entry register window. Most addresses only store a value. Four addresses start a new DMA session, and each one picks a different session kind. A normal or enhanced session reads its descriptor list through a 28-bit linear memory port. A CPU-mapped session reads it through a 16-bit port that sees the CPU's address space. A fourth kind takes the list pointer from the live CPU program counter and returns the advanced pointer to the PC when the job ends.

The descriptor decoder sits downstream and is not part of this unit. It asks for list bytes one at a time with `fetchReq`. It receives each byte on `listByteValid`/`listByte`, and it reports the end of each descriptor with `descDone` together with the chained flag `chainIn`. Each fetch uses a valid/ready request and then a response beat on exactly one of the two memory ports. The unit also provides busy status, the enhanced-mode flag, the active revision bit, the byte-skip (transparency) setting and a sticky error flag.

Top module: `dma_list_seq`

## Requirements
- R1: A write to address 0 starts a normal session: `enhanced`=0 and `busyStatus`=0x80. The list address is {reg4[7:0], reg2[3:0], reg1[7:0], written byte}, and the list is fetched on the linear port.
- R2: A write to address 5 starts an enhanced session (`enhanced`=1). The list address is the same 28-bit value as in R1, and the list is fetched on the linear port.
- R3: A write to address 6 starts an enhanced session whose list is fetched on the CPU port, starting at {reg1, written byte}. CPU-port addresses wrap from 0xFFFF to 0x0000.
- R4: A write to address 7 starts an enhanced session on the CPU port. The list address is loaded from `cpuPc` when the first byte is requested, not when the write happens. When this session ends unchained, `pcWrEn` pulses for one cycle with `pcWrData` equal to the low 16 bits of the current list address.
- R5: A write to address 2 stores reg2 and clears reg4. Writes to addresses 1, 2, 3, 4, 0xE and every other address outside {0,5,6,7} never start a session and leave `busyStatus` at 0x00.
- R6: Bit 0 of a write to address 3 sets the default revision. Each accepted session start copies the default into `revision`, and `revision` does not change while a session runs.
- R7: Linear list addresses increment by one per byte delivered. They carry past 0xFFFF and past 0xFFFFF, and they wrap only at 28 bits.
- R8: A session start sets `busyStatus` to 0x80, sets `needCmd` to 1 and clears `transpOn`. `needCmd` goes to 0 after the next list byte is delivered.
- R9: A start write (address 0, 5, 6 or 7) that arrives while `busyStatus` is 0x80 is ignored: the list address and mode are unchanged. It sets the sticky `errFlag`, which only reset clears.
- R10: A port's request valid stays high with a stable address until that port's ready is seen. Only the port selected by the session mode raises valid. Each response beat delivers exactly one byte on `listByte` one cycle later.
- R11: `descDone` with `chainIn`=1 keeps `busyStatus` at 0x80, sets `needCmd` to 1 and keeps the list address. It produces no `pcWrEn`.
- R12: `descDone` with `chainIn`=0 returns `busyStatus` to 0x00. For every session kind except the address-7 kind, `pcWrEn` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 4 | Register address |
| regWrData | input | 8 | Register write data |
| cpuPc | input | 16 | Live CPU program counter |
| pcWrEn | output | 1 | Program-counter writeback strobe |
| pcWrData | output | 16 | Program-counter writeback value |
| fetchReq | input | 1 | Decoder asks for the next list byte |
| descDone | input | 1 | Decoder finished a descriptor |
| chainIn | input | 1 | Chained flag, sampled with descDone |
| optTranspEn | input | 1 | Decoder loads a transparency value |
| optTranspVal | input | 8 | Transparency value to load |
| linReqValid | output | 1 | Linear port request valid |
| linReqReady | input | 1 | Linear port request ready |
| linAddr | output | 28 | Linear port byte address |
| linRspValid | input | 1 | Linear port response valid |
| linRspData | input | 8 | Linear port response byte |
| cpuReqValid | output | 1 | CPU port request valid |
| cpuReqReady | input | 1 | CPU port request ready |
| cpuAddr | output | 16 | CPU port byte address |
| cpuRspValid | input | 1 | CPU port response valid |
| cpuRspData | input | 8 | CPU port response byte |
| listByteValid | output | 1 | List byte delivered |
| listByte | output | 8 | Delivered list byte |
| needCmd | output | 1 | Next byte is a command byte |
| busyStatus | output | 8 | 0x80 while a session runs, else 0x00 |
| enhanced | output | 1 | Enhanced session flag |
| revision | output | 1 | Active revision bit |
| transpOn | output | 1 | Transparency value in force |
| transpVal | output | 8 | Transparency byte value |
| errFlag | output | 1 | Sticky start-while-busy error |

## Verification
The bench checks the address boundaries. A linear list that crosses 0xFFFF or 0xFFFFF must carry into the upper bits rather than wrap the way the 16-bit CPU port does. A CPU-port list at 0xFFFF must return to 0x0000 rather than reach 0x10000. For the address-7 session, it changes `cpuPc` between the start write and the first fetch, so a design that samples the PC too early shows the wrong address. It also checks the writeback value after several bytes, so a design that writes back a stale pointer, or writes back after a chained descriptor, is exposed. It covers a start write during a busy session, the reg4 clear done by a reg2 write, and a revision change in mid-session, because a wrong design would restart, keep a stale megabyte, or take the new revision too early.

// File: rtl/dma_list_pkg.sv
package dma_list_pkg;
  localparam int LIN_AW = 28;
  localparam int CPU_AW = 16;

  typedef enum logic [1:0] {
    MODE_LIN   = 2'd0,
    MODE_CPU   = 2'd1,
    MODE_PCPND = 2'd2,
    MODE_CPUWB = 2'd3
  } list_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_REQ  = 2'd2,
    ST_RSP  = 2'd3
  } seq_state_e;

  typedef struct packed {
    logic wrStore;
    logic loadLin;
    logic loadCpu;
    logic loadPc;
    logic incAddr;
    logic cpuWrap;
    logic capture;
    logic newSess;
  } seq_strobe_t;
endpackage

// File: rtl/dma_list_dp.sv
module dma_list_dp
  import dma_list_pkg::*;
#(
  parameter int LAW = LIN_AW,
  parameter int CAW = CPU_AW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  seq_strobe_t       stb,
  input  logic [3:0]        regAddr,
  input  logic [7:0]        regWrData,
  input  logic [CAW-1:0]    cpuPc,
  input  logic              optTranspEn,
  input  logic [7:0]        optTranspVal,
  input  logic [7:0]        linRspData,
  input  logic [7:0]        cpuRspData,
  output logic [LAW-1:0]    listAddr,
  output logic [7:0]        listByte,
  output logic              revision,
  output logic              transpOn,
  output logic [7:0]        transpVal
);
  localparam int UPW = LAW - CAW;

  logic [7:0] reg1, reg4;
  logic [3:0] reg2Lo;
  logic       defRev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg1   <= '0;
      reg2Lo <= '0;
      reg4   <= '0;
      defRev <= 1'b0;
    end else if (stb.wrStore) begin
      case (regAddr)
        4'h1: reg1 <= regWrData;
        4'h2: begin
          reg2Lo <= regWrData[3:0];
          reg4   <= '0;
        end
        4'h3: defRev <= regWrData[0];
        4'h4: reg4 <= regWrData;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      listAddr <= '0;
    end else if (stb.loadLin) begin
      listAddr <= LAW'({reg4, reg2Lo, reg1, regWrData});
    end else if (stb.loadCpu) begin
      listAddr <= {{UPW{1'b0}}, reg1, regWrData};
    end else if (stb.loadPc) begin
      listAddr <= {{UPW{1'b0}}, cpuPc};
    end else if (stb.incAddr) begin
      if (stb.cpuWrap) listAddr <= {{UPW{1'b0}}, listAddr[CAW-1:0] + CAW'(1)};
      else             listAddr <= listAddr + LAW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      listByte  <= '0;
      revision  <= 1'b0;
      transpOn  <= 1'b0;
      transpVal <= '0;
    end else begin
      if (stb.capture) listByte <= stb.cpuWrap ? cpuRspData : linRspData;
      if (stb.newSess) begin
        revision <= defRev;
        transpOn <= 1'b0;
      end else if (optTranspEn) begin
        transpOn  <= 1'b1;
        transpVal <= optTranspVal;
      end
    end
  end

  assert_cpuwrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.incAddr && stb.cpuWrap) |=> (listAddr[LAW-1:CAW] == '0));
  assert_carry_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.incAddr && !stb.cpuWrap && !stb.loadLin && !stb.loadCpu && !stb.loadPc
     && $past(rst_n)) |=> (listAddr != $past(listAddr)));
endmodule

// File: rtl/dma_list_ctrl.sv
module dma_list_ctrl
  import dma_list_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        regWrEn,
  input  logic [3:0]  regAddr,
  input  logic        fetchReq,
  input  logic        descDone,
  input  logic        chainIn,
  input  logic        linReqReady,
  input  logic        linRspValid,
  input  logic        cpuReqReady,
  input  logic        cpuRspValid,
  output seq_strobe_t stb,
  output logic        linReqValid,
  output logic        cpuReqValid,
  output logic        listByteValid,
  output logic        pcWrEn,
  output logic        needCmd,
  output logic        busy,
  output logic        enhanced,
  output logic        errFlag
);
  seq_state_e state;
  list_mode_e mode;
  logic isStart, startOk, cpuSel, reqReady, rspValid;

  assign isStart  = regWrEn && (regAddr == 4'h0 || regAddr == 4'h5 ||
                                regAddr == 4'h6 || regAddr == 4'h7);
  assign startOk  = isStart && (state == ST_IDLE);
  assign cpuSel   = (mode != MODE_LIN);
  assign reqReady = cpuSel ? cpuReqReady : linReqReady;
  assign rspValid = cpuSel ? cpuRspValid : linRspValid;
  assign busy     = (state != ST_IDLE);

  assign linReqValid = (state == ST_REQ) && !cpuSel;
  assign cpuReqValid = (state == ST_REQ) && cpuSel;

  always_comb begin
    stb         = '0;
    stb.wrStore = regWrEn && !isStart;
    stb.cpuWrap = cpuSel;
    stb.newSess = startOk;
    stb.loadLin = startOk && (regAddr == 4'h0 || regAddr == 4'h5);
    stb.loadCpu = startOk && (regAddr == 4'h6);
    stb.loadPc  = (state == ST_WAIT) && fetchReq && !descDone && (mode == MODE_PCPND);
    stb.capture = (state == ST_RSP) && rspValid;
    stb.incAddr = stb.capture;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state         <= ST_IDLE;
      mode          <= MODE_LIN;
      enhanced      <= 1'b0;
      errFlag       <= 1'b0;
      needCmd       <= 1'b0;
      pcWrEn        <= 1'b0;
      listByteValid <= 1'b0;
    end else begin
      pcWrEn        <= 1'b0;
      listByteValid <= 1'b0;
      if (isStart && !startOk) errFlag <= 1'b1;
      if (startOk) begin
        state    <= ST_WAIT;
        needCmd  <= 1'b1;
        enhanced <= (regAddr != 4'h0);
        case (regAddr)
          4'h6:    mode <= MODE_CPU;
          4'h7:    mode <= MODE_PCPND;
          default: mode <= MODE_LIN;
        endcase
      end else begin
        case (state)
          ST_WAIT: begin
            if (descDone) begin
              if (chainIn) begin
                needCmd <= 1'b1;
              end else begin
                state  <= ST_IDLE;
                pcWrEn <= (mode == MODE_CPUWB);
              end
            end else if (fetchReq) begin
              state <= ST_REQ;
              if (mode == MODE_PCPND) mode <= MODE_CPUWB;
            end
          end
          ST_REQ: if (reqReady) state <= ST_RSP;
          ST_RSP: if (rspValid) begin
            state         <= ST_WAIT;
            listByteValid <= 1'b1;
            needCmd       <= 1'b0;
          end
          default: ;
        endcase
      end
    end
  end

  assert_linhold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (linReqValid && !linReqReady) |=> linReqValid);
  assert_cpuhold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cpuReqValid && !cpuReqReady) |=> cpuReqValid);
  assert_errcause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(errFlag) |-> ($past(regWrEn) && $past(busy)));
  assert_wbend_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pcWrEn |-> (!busy && $past(descDone) && !$past(chainIn)));
  assert_onebyte_R10: assert property (@(posedge clk) disable iff (!rst_n)
    listByteValid |-> $past(state == ST_RSP));
endmodule

// File: rtl/dma_list_seq.sv
module dma_list_seq
  import dma_list_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        regWrEn,
  input  logic [3:0]  regAddr,
  input  logic [7:0]  regWrData,
  input  logic [15:0] cpuPc,
  output logic        pcWrEn,
  output logic [15:0] pcWrData,
  input  logic        fetchReq,
  input  logic        descDone,
  input  logic        chainIn,
  input  logic        optTranspEn,
  input  logic [7:0]  optTranspVal,
  output logic        linReqValid,
  input  logic        linReqReady,
  output logic [27:0] linAddr,
  input  logic        linRspValid,
  input  logic [7:0]  linRspData,
  output logic        cpuReqValid,
  input  logic        cpuReqReady,
  output logic [15:0] cpuAddr,
  input  logic        cpuRspValid,
  input  logic [7:0]  cpuRspData,
  output logic        listByteValid,
  output logic [7:0]  listByte,
  output logic        needCmd,
  output logic [7:0]  busyStatus,
  output logic        enhanced,
  output logic        revision,
  output logic        transpOn,
  output logic [7:0]  transpVal,
  output logic        errFlag
);
  seq_strobe_t stb;
  logic [LIN_AW-1:0] listAddr;
  logic busy;

  dma_list_ctrl u_ctrl (
    .clk, .rst_n, .regWrEn, .regAddr, .fetchReq, .descDone, .chainIn,
    .linReqReady, .linRspValid, .cpuReqReady, .cpuRspValid,
    .stb, .linReqValid, .cpuReqValid, .listByteValid, .pcWrEn,
    .needCmd, .busy, .enhanced, .errFlag
  );

  dma_list_dp #(.LAW(LIN_AW), .CAW(CPU_AW)) u_dp (
    .clk, .rst_n, .stb, .regAddr, .regWrData, .cpuPc,
    .optTranspEn, .optTranspVal, .linRspData, .cpuRspData,
    .listAddr, .listByte, .revision, .transpOn, .transpVal
  );

  assign linAddr    = listAddr;
  assign cpuAddr    = listAddr[CPU_AW-1:0];
  assign pcWrData   = listAddr[CPU_AW-1:0];
  assign busyStatus = busy ? 8'h80 : 8'h00;
endmodule

// File: tb/dma_list_seq_tb.sv
`timescale 1ns/1ps
module dma_list_seq_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic regWrEn = 0; logic [3:0] regAddr = 0; logic [7:0] regWrData = 0;
  logic [15:0] cpuPc = 0;
  logic pcWrEn; logic [15:0] pcWrData;
  logic fetchReq = 0, descDone = 0, chainIn = 0, optTranspEn = 0;
  logic [7:0] optTranspVal = 0;
  logic linReqValid, linReqReady = 0, linRspValid = 0; logic [27:0] linAddr; logic [7:0] linRspData = 0;
  logic cpuReqValid, cpuReqReady = 0, cpuRspValid = 0; logic [15:0] cpuAddr; logic [7:0] cpuRspData = 0;
  logic listByteValid, needCmd, enhanced, revision, transpOn, errFlag;
  logic [7:0] listByte, busyStatus, transpVal;
  int errors = 0, checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dma_list_seq u_dut (.*);

  typedef struct packed {
    logic [3:0] sreg; logic [7:0] data; logic [7:0] r1; logic [7:0] r2;
    logic [7:0] r4; logic expCpu; logic [27:0] expAddr; logic expEnh;
  } vec_t;
  localparam vec_t VECS [5] = '{
    '{4'h0, 8'h44, 8'h22, 8'h13, 8'h05, 1'b0, 28'h0532244, 1'b0},
    '{4'h5, 8'h01, 8'hAB, 8'hF7, 8'hFF, 1'b0, 28'hFF7AB01, 1'b1},
    '{4'h6, 8'h9C, 8'h4D, 8'h00, 8'h00, 1'b1, 28'h0004D9C, 1'b1},
    '{4'h0, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0, 28'h0000000, 1'b0},
    '{4'h6, 8'h00, 8'h00, 8'h0F, 8'h33, 1'b1, 28'h0000000, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    regWrEn = 1; regAddr = a; regWrData = d;
    @(negedge clk); regWrEn = 0;
  endtask

  task automatic fetch(input string req, input bit useCpu, input logic [27:0] expAddr,
                       input logic [7:0] data, input int stall);
    fetchReq = 1; @(negedge clk); fetchReq = 0;
    for (int s = 0; s < stall; s++) begin
      @(negedge clk);
      chk({req, " valid held"}, useCpu ? cpuReqValid : linReqValid, 1);
    end
    chk({req, " port sel"}, {linReqValid, cpuReqValid}, useCpu ? 2'b01 : 2'b10);
    chk({req, " addr"}, useCpu ? {16'h0, cpuAddr} : {4'h0, linAddr}, {4'h0, expAddr});
    if (useCpu) cpuReqReady = 1; else linReqReady = 1;
    @(negedge clk);
    cpuReqReady = 0; linReqReady = 0;
    if (useCpu) begin cpuRspValid = 1; cpuRspData = data; end
    else begin linRspValid = 1; linRspData = data; end
    @(negedge clk);
    cpuRspValid = 0; linRspValid = 0;
    chk({req, " byte valid"}, listByteValid, 1);
    chk({req, " byte"}, listByte, data);
    @(negedge clk);
    chk({req, " single byte"}, listByteValid, 0);
  endtask

  task automatic endDesc(input bit chained);
    descDone = 1; chainIn = chained; @(negedge clk); descDone = 0; chainIn = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1; @(negedge clk);
    chk("R12 reset busy", busyStatus, 8'h00);
    chk("R9 reset err", errFlag, 0);
    chk("R10 reset ports", {linReqValid, cpuReqValid}, 0);

    for (int i = 0; i < 5; i++) begin
      wr(4'h1, VECS[i].r1); wr(4'h2, VECS[i].r2); wr(4'h4, VECS[i].r4);
      chk("R5 no start", busyStatus, 8'h00);
      wr(VECS[i].sreg, VECS[i].data);
      chk("R8 busy", busyStatus, 8'h80);
      chk("R8 needCmd", needCmd, 1);
      chk("R1 R2 R3 enhanced", enhanced, VECS[i].expEnh);
      fetch("R1 R2 R3 table", VECS[i].expCpu, VECS[i].expAddr, 8'hA0 + 8'(i), 0);
      chk("R8 needCmd clear", needCmd, 0);
      endDesc(0);
      chk("R12 end busy", busyStatus, 8'h00);
      chk("R12 no writeback", pcWrEn, 0);
    end

    // R5: reg2 clears reg4; 0xE and others do not start
    wr(4'h4, 8'h12); wr(4'h1, 8'h22); wr(4'h2, 8'h03);
    wr(4'hE, 8'h55); wr(4'h9, 8'h01);
    chk("R5 0xE no start", busyStatus, 8'h00);
    wr(4'h0, 8'h44);
    fetch("R5 megabyte cleared", 0, 28'h0032244, 8'h11, 1);
    endDesc(0);

    // R7 carry past 64K and 1M, wrap at 28 bits
    wr(4'h1, 8'hFF); wr(4'h2, 8'h00); wr(4'h4, 8'h00); wr(4'h0, 8'hFF);
    fetch("R7 64K a", 0, 28'h000FFFF, 8'h01, 0);
    fetch("R7 64K carry", 0, 28'h0010000, 8'h02, 0);
    endDesc(0);
    wr(4'h2, 8'h0F); wr(4'h5, 8'hFF);
    fetch("R7 1M a", 0, 28'h00FFFFF, 8'h03, 0);
    fetch("R7 1M carry", 0, 28'h0100000, 8'h04, 0);
    endDesc(0);
    wr(4'h4, 8'hFF); wr(4'h0, 8'hFF);
    fetch("R7 28b a", 0, 28'hFFFFFFF, 8'h05, 0);
    fetch("R7 28b wrap", 0, 28'h0000000, 8'h06, 0);
    endDesc(0);

    // R3 CPU wrap
    wr(4'h1, 8'hFF); wr(4'h6, 8'hFF);
    fetch("R3 cpu a", 1, 28'h000FFFF, 8'h07, 2);
    fetch("R3 cpu wrap", 1, 28'h0000000, 8'h08, 0);
    // R11 chained, R9 start while busy
    endDesc(1);
    chk("R11 busy kept", busyStatus, 8'h80);
    chk("R11 needCmd", needCmd, 1);
    chk("R11 no wb", pcWrEn, 0);
    wr(4'h0, 8'h77);
    chk("R9 err", errFlag, 1);
    chk("R9 busy", busyStatus, 8'h80);
    fetch("R9 R11 addr kept", 1, 28'h0000001, 8'h09, 0);
    endDesc(0);
    chk("R12 cpu end no wb", pcWrEn, 0);
    chk("R9 err sticky", errFlag, 1);

    // R4 PC session
    cpuPc = 16'h1111;
    wr(4'h7, 8'h00);
    chk("R4 enhanced", enhanced, 1);
    cpuPc = 16'h1234;
    fetch("R4 pc at fetch", 1, 28'h0001234, 8'h21, 0);
    fetch("R4 next", 1, 28'h0001235, 8'h22, 0);
    endDesc(1);
    chk("R4 R11 chained no wb", pcWrEn, 0);
    fetch("R4 after chain", 1, 28'h0001236, 8'h23, 0);
    endDesc(0);
    chk("R4 wb strobe", pcWrEn, 1);
    chk("R4 wb value", pcWrData, 16'h1237);
    @(negedge clk);
    chk("R4 wb one cycle", pcWrEn, 0);

    // R6 revision, R8 transparency
    wr(4'h3, 8'h01);
    chk("R6 no start", busyStatus, 8'h00);
    wr(4'h0, 8'h00);
    chk("R6 revision copy", revision, 1);
    optTranspEn = 1; optTranspVal = 8'h5A; @(negedge clk); optTranspEn = 0;
    chk("R8 transp set", {transpOn, transpVal}, 9'h15A);
    wr(4'h3, 8'h00);
    chk("R6 revision stable", revision, 1);
    endDesc(0);
    wr(4'h5, 8'h00);
    chk("R6 new revision", revision, 0);
    chk("R8 transp cleared", transpOn, 0);
    endDesc(0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule